// File: doc/BRIEF.md
# Registered Bidirectional Barrel Shifter

This block takes a 16-bit word, a 4-bit shift count, a direction select and a sign-mode select. It captures all of them on the rising clock edge and then moves the captured word by 0 to 15 bit positions. During the following cycle the shifted result appears on the output. No clock edge is needed between the register and the output.

Right shifts come in two kinds. The first is logical and fills with zeros. The second is arithmetic and replicates the top bit of the captured word. Left shifts always bring in zeros.

The datapath is made only of primitive gates. One log-depth network with four multiplexer stages (distances 1, 2, 4 and 8) serves both directions. A left shift is handled by bit-reversing the word on the way into the network and again on the way out, so the same right-shifting stages do the work.

Top module: `barrel_shift_reg`

## Requirements
- R1: Each input is sampled at a rising clock edge. The output during the cycle after that edge is a function of the sampled values only. A change on the inputs between edges leaves the output unchanged.
- R2: The reset `rst_n` is active-low and synchronous. An edge with `rst_n` low clears every captured value to zero, so `data_out` reads 0x0000 during the next cycle.
- R3: A captured shift count of 0 gives the captured word unchanged, for both directions and both sign modes.
- R4: With `shift_right`=1 and `sign_mode`=0, the output is the captured word shifted right by the count. The vacated upper bits are zero.
- R5: With `shift_right`=1 and `sign_mode`=1, the output is the captured word shifted right by the count. Every vacated upper bit equals bit 15 of the captured word.
- R6: With `shift_right`=0, the output is the captured word shifted left by the count. The vacated lower bits are zero whatever `sign_mode` holds.
- R7: Every count from 0 to 15 is honoured. At a count of 15, a right shift leaves only the old bit 15 in bit 0, or a full word of sign copies in arithmetic mode. A left shift leaves only the old bit 0 in bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 16 | Word to be shifted |
| shift_amt | input | 4 | Number of positions, 0 to 15 |
| shift_right | input | 1 | 1 = shift toward bit 0, 0 = shift toward bit 15 |
| sign_mode | input | 1 | 1 = arithmetic right shift (sign copies), 0 = zero fill |
| data_out | output | 16 | Shifted result of the previously captured inputs |

## Verification
The bench runs every count in both directions and both sign modes. It uses words that stress the fill logic: 0x8000, 0x7FFF, 0xFFFF and 0x0001, plus random words.

The following faults are exposed by these cases:
- A fill gate that ignores the direction would smear ones into the low bits of a left shift of 0x8000 in sign mode.
- A fill gate that ignores the mode would corrupt a logical right shift of 0xFFFF.
- A stage wired to the wrong count bit, or with the wrong distance, shows up as soon as counts 1, 2, 4 and 8 are compared.
- A missing or mis-wired reversal breaks every left shift by a nonzero count.

The bench also changes the inputs between edges and checks the output before the next edge. A design that bypassed the capture register would fail that check.

// File: rtl/barrel_shift_pkg.sv
// Package: shared sizing for the registered barrel shifter.
// Assumes: word width is a power of two; count width is its log2.
package barrel_shift_pkg;
    localparam int WORD_W  = 16;
    localparam int COUNT_W = $clog2(WORD_W);
endpackage

// File: rtl/bs_mux2.sv
// Module: bs_mux2
// Selects d1 when sel is high, otherwise d0, built from primitive gates.
// Assumes: single-bit operands; no glitch filtering is required.
module bs_mux2 (
    input  logic d0,
    input  logic d1,
    input  logic sel,
    output logic y
);
    logic sel_n;
    logic pick0;
    logic pick1;

    // Invert select, gate each leg, merge the legs.
    not u_inv  (sel_n, sel);
    and u_and0 (pick0, d0, sel_n);
    and u_and1 (pick1, d1, sel);
    or  u_or   (y, pick0, pick1);
endmodule

// File: rtl/bs_capture.sv
// Module: bs_capture
// Samples word, count, direction and mode on the rising edge.
// Assumes: synchronous active-low reset; reset value is all zeros.
module bs_capture #(
    parameter int W  = barrel_shift_pkg::WORD_W,
    parameter int CW = barrel_shift_pkg::COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  word_in,
    input  logic [CW-1:0] count_in,
    input  logic          right_in,
    input  logic          arith_in,
    output logic [W-1:0]  word_q,
    output logic [CW-1:0] count_q,
    output logic          right_q,
    output logic          arith_q
);
    // Capture every control and data input once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            count_q <= '0;
            right_q <= 1'b0;
            arith_q <= 1'b0;
        end else begin
            word_q  <= word_in;
            count_q <= count_in;
            right_q <= right_in;
            arith_q <= arith_in;
        end
    end
endmodule

// File: rtl/bs_orient.sv
// Module: bs_orient
// Passes the word straight through when keep is high, else bit-reverses it.
// Assumes: used on both sides of the network, so two reversals cancel.
module bs_orient #(
    parameter int W = barrel_shift_pkg::WORD_W
) (
    input  logic [W-1:0] d,
    input  logic         keep,
    output logic [W-1:0] y
);
    // One gate-level mux per bit: straight bit versus mirrored bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        bs_mux2 u_mux (
            .d0  (d[W-1-i]),
            .d1  (d[i]),
            .sel (keep),
            .y   (y[i])
        );
    end
endmodule

// File: rtl/bs_stage.sv
// Module: bs_stage
// One rank of the log shifter: moves the word DIST places toward bit 0 when en is high.
// Assumes: vacated upper positions take the shared fill bit.
module bs_stage #(
    parameter int W    = barrel_shift_pkg::WORD_W,
    parameter int DIST = 1
) (
    input  logic [W-1:0] d,
    input  logic         en,
    input  logic         fill,
    output logic [W-1:0] y
);
    // Per bit: choose the unshifted bit or the bit DIST above it (or fill).
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i + DIST < W) begin : g_inner
            bs_mux2 u_mux (
                .d0  (d[i]),
                .d1  (d[i+DIST]),
                .sel (en),
                .y   (y[i])
            );
        end else begin : g_edge
            bs_mux2 u_mux (
                .d0  (d[i]),
                .d1  (fill),
                .sel (en),
                .y   (y[i])
            );
        end
    end
endmodule

// File: rtl/barrel_shift_reg.sv
// Module: barrel_shift_reg (top)
// Registered 16-bit shifter: capture, orient, four log stages, orient back.
// Assumes: the output is combinational from the capture register, valid one cycle after sampling.
module barrel_shift_reg #(
    parameter int W  = barrel_shift_pkg::WORD_W,
    parameter int CW = barrel_shift_pkg::COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   data_in,
    input  logic [3:0]    shift_amt,
    input  logic          shift_right,
    input  logic          sign_mode,
    output logic [15:0]   data_out
);
    localparam int STAGES = CW;

    logic [W-1:0]  word_q;
    logic [CW-1:0] count_q;
    logic          right_q;
    logic          arith_q;
    logic          fill_bit;
    logic [W-1:0]  lvl [STAGES+1];

    bs_capture #(.W(W), .CW(CW)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (data_in),
        .count_in (shift_amt),
        .right_in (shift_right),
        .arith_in (sign_mode),
        .word_q   (word_q),
        .count_q  (count_q),
        .right_q  (right_q),
        .arith_q  (arith_q)
    );

    // Sign copies only for arithmetic right shifts; left shifts see zero.
    and u_fill (fill_bit, right_q, arith_q, word_q[W-1]);

    bs_orient #(.W(W)) u_orient_in (
        .d    (word_q),
        .keep (right_q),
        .y    (lvl[0])
    );

    // Stage k moves by 2**k under control of count bit k.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        bs_stage #(.W(W), .DIST(1 << k)) u_stage (
            .d    (lvl[k]),
            .en   (count_q[k]),
            .fill (fill_bit),
            .y    (lvl[k+1])
        );
    end

    bs_orient #(.W(W)) u_orient_out (
        .d    (lvl[STAGES]),
        .keep (right_q),
        .y    (data_out)
    );
endmodule

// File: rtl/barrel_shift_chk.sv
// Module: barrel_shift_chk
// Checker comparing the structural network against behavioural shifts of the last sampled inputs.
// Assumes: bound to barrel_shift_reg; checks start after the first reset.
module barrel_shift_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] data_in,
    input logic [3:0]  shift_amt,
    input logic        shift_right,
    input logic        sign_mode,
    input logic [15:0] data_out
);
    logic        armed = 1'b0;
    logic        was_rst_q = 1'b0;
    logic [15:0] d_q = '0;
    logic [3:0]  a_q = '0;
    logic        r_q = 1'b0;
    logic        s_q = 1'b0;
    logic        live;

    // Shadow copy of what the design should have sampled.
    always_ff @(posedge clk) begin
        armed     <= armed | !rst_n;
        was_rst_q <= !rst_n;
        d_q       <= data_in;
        a_q       <= shift_amt;
        r_q       <= shift_right;
        s_q       <= sign_mode;
    end

    assign live = armed && !was_rst_q;

    p_reset_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> data_out == 16'h0000);

    p_zero_count_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && a_q == 4'd0) |-> data_out == d_q);

    p_right_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && r_q && !s_q) |-> data_out == (d_q >> a_q));

    p_right_sign_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && r_q && s_q) |-> data_out == $unsigned($signed(d_q) >>> a_q));

    p_left_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !r_q) |-> data_out == (d_q << a_q));

    p_full_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && a_q == 4'd15 && !r_q) |-> data_out == {d_q[0], 15'h0000});
endmodule

bind barrel_shift_reg barrel_shift_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_in     (data_in),
    .shift_amt   (shift_amt),
    .shift_right (shift_right),
    .sign_mode   (sign_mode),
    .data_out    (data_out)
);

// File: tb/test_barrel_shift_reg.sv
module test_barrel_shift_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_in = '0;
    logic [3:0]  shift_amt = '0;
    logic        shift_right = 1'b0;
    logic        sign_mode = 1'b0;
    logic [15:0] data_out;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    barrel_shift_reg i_barrel_shift_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_in     (data_in),
        .shift_amt   (shift_amt),
        .shift_right (shift_right),
        .sign_mode   (sign_mode),
        .data_out    (data_out)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] expect_shift(input logic [15:0] d, input logic [3:0] a,
                                                 input logic r, input logic s);
        logic signed [15:0] sd;
        sd = d;
        if (r && s) return $unsigned(sd >>> a);
        if (r)      return d >> a;
        return d << a;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at negedge, sample at the following negedge (one capture edge between).
    task automatic run_one(input logic [15:0] d, input logic [3:0] a, input logic r,
                           input logic s, input bit probe_hold);
        logic [15:0] prev;
        string tag;
        @(negedge clk);
        prev = data_out;
        data_in = d; shift_amt = a; shift_right = r; sign_mode = s;
        if (probe_hold) begin
            #2;
            check("R1 hold before edge", data_out, prev);
        end
        @(negedge clk);
        if (a == 4'd0)      tag = "R3 zero count";
        else if (a == 4'd15) tag = "R7 count 15";
        else if (r && s)    tag = "R5 arithmetic right";
        else if (r)         tag = "R4 logical right";
        else                tag = "R6 left";
        check(tag, data_out, expect_shift(d, a, r, s));
    endtask

    initial begin
        logic [15:0] words [8];
        void'($urandom(32'h5eed_1234));
        words[0] = 16'h8000; words[1] = 16'h7FFF;
        words[2] = 16'hFFFF; words[3] = 16'h0001;
        for (int i = 4; i < 8; i++) words[i] = 16'($urandom());

        data_in = 16'hA5A5; shift_amt = 4'd3; shift_right = 1'b1; sign_mode = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 reset clears", data_out, 16'h0000);
        rst_n = 1'b1;

        for (int w = 0; w < 8; w++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 2; s++)
                    for (int a = 0; a < 16; a++)
                        run_one(words[w], 4'(a), 1'(r), 1'(s), (a % 5) == 0);

        // R6: left shift of a negative word ignores sign mode.
        run_one(16'h8001, 4'd1, 1'b0, 1'b1, 1'b0);

        for (int n = 0; n < 300; n++)
            run_one(16'($urandom()), 4'($urandom()), 1'($urandom()), 1'($urandom()), n % 7 == 0);

        // R2: reset mid-run after a nonzero result.
        run_one(16'hFFFF, 4'd0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 mid-run reset", data_out, 16'h0000);
        rst_n = 1'b1;
        run_one(16'h8000, 4'd15, 1'b1, 1'b1, 1'b0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule